// File: doc/BRIEF.md
# Pipelined Handshaked Sixteen-Way Bit Selector

The block is a 4-input look-up table built as a 16:1 single-bit multiplexer. It is not one combinational tree. A token holds 16 leaf bits and a 4-bit select code, and it enters on a valid/ready handshake. The token then passes through four registered stages, and each stage halves the leaf vector with one layer of 2:1 selection.

Each stage uses one select bit, starting from the least significant one. The select bits that are still unused travel with the narrowed data. Every stage therefore resolves its choice with the code that belongs to its own token.

Stages are joined by elastic full/empty slots. A token moves forward only when its slot is full and the next slot is empty. The last slot drives the output directly. Up to four tokens can be in flight, and output backpressure stalls the chain without dropping or reordering tokens.

Top module: `lut_pipe_mux`

## Requirements
- R1: After reset (rst_ni low), out_valid_o is 0 and in_ready_o is 1.
- R2: For an accepted token, out_bit_o equals in_data_i[in_sel_i], where in_sel_i[3] is the most significant select bit and in_data_i[0] is selected by code 0.
- R3: in_ready_o is high only while the first stage holds no token. A token is taken on a rising edge where in_valid_o... in_valid_i and in_ready_o are both high.
- R4: With the pipeline empty and out_ready_i high, a token accepted at a given edge shows out_valid_o high after exactly four rising edges (counting the accepting edge), and out_valid_o stays low before that.
- R5: Results leave in acceptance order, and each accepted token produces exactly one result, under any pattern of out_ready_i.
- R6: While out_valid_o is high and out_ready_i is low, out_valid_o stays high and out_bit_o stays unchanged on the next cycle.
- R7: With out_ready_i held low, the block accepts exactly four tokens and then holds in_ready_o low.
- R8: With in_valid_i and out_ready_i held high from reset, the block accepts one token every second cycle (10 tokens in 20 cycles).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input token present |
| in_ready_o | output | 1 | First stage empty, token can be taken |
| in_data_i | input | 16 | Leaf bits of the table |
| in_sel_i | input | 4 | Select code, bit 3 most significant |
| out_valid_o | output | 1 | Result present |
| out_ready_i | input | 1 | Consumer takes the result |
| out_bit_o | output | 1 | Selected leaf bit |

## Verification
A select bit that is misaligned with its token shows up as a wrong out_bit_o for some select code. It appears on the first result whose leaf pattern tells the two candidates apart, which is at most four edges after acceptance. A slot that loses or duplicates a token shows up as a miscompare against the ordered expectation queue at the next output handshake. A slot that ignores backpressure shows up as an output that changes during a stall within one cycle. A wrong occupancy rule shows up as an accept count off the expected value within twenty cycles.

// File: rtl/lut_pipe_pkg.sv
package lut_pipe_pkg;
  localparam int unsigned SEL_W_DEF = 4;

  // leaf bits remaining at the output of stage s
  function automatic int unsigned leaf_after(int unsigned sel_w, int unsigned s);
    return (1 << sel_w) >> (s + 1);
  endfunction

  // select bits still unused after stage s
  function automatic int unsigned sel_after(int unsigned sel_w, int unsigned s);
    return sel_w - s - 1;
  endfunction
endpackage

// File: rtl/lut_fold.sv
module lut_fold #(
  parameter int unsigned IN_W = 16
) (
  input  logic [IN_W-1:0]   in_i,
  input  logic              pick_i,
  output logic [IN_W/2-1:0] out_o
);
  localparam int unsigned OUT_W = IN_W / 2;

  for (genvar k = 0; k < OUT_W; k++) begin : g_pair
    assign out_o[k] = pick_i ? in_i[2*k+1] : in_i[2*k];
  end
endmodule

// File: rtl/lut_slot.sv
module lut_slot #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  output logic         ready_o,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  input  logic         ready_i,
  output logic [W-1:0] data_o
);
  logic         full_q;
  logic [W-1:0] pay_q;
  logic         load, drain;

  assign ready_o = ~full_q;
  assign load    = valid_i & ~full_q;
  assign drain   = full_q & ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      pay_q  <= '0;
    end else begin
      if (load) begin
        full_q <= 1'b1;
        pay_q  <= data_i;
      end else if (drain) begin
        full_q <= 1'b0;
      end
    end
  end

  assign valid_o = full_q;
  assign data_o  = pay_q;

  a_r3_accept_fills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> valid_o);

  a_r3_no_ghost_token: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o && !valid_i) |=> !valid_o);

  a_r6_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));
endmodule

// File: rtl/lut_pipe_mux.sv
module lut_pipe_mux
  import lut_pipe_pkg::*;
#(
  parameter int unsigned SEL_W = SEL_W_DEF,
  localparam int unsigned LEAF_N = 1 << SEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [LEAF_N-1:0] in_data_i,
  input  logic [SEL_W-1:0]  in_sel_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic              out_bit_o
);
  // stage boundaries: index s feeds stage s
  logic [LEAF_N-1:0] dat_b [SEL_W+1];
  logic [SEL_W-1:0]  sel_b [SEL_W+1];
  logic              vld_b [SEL_W+1];
  logic              rdy_b [SEL_W+1];

  assign dat_b[0]    = in_data_i;
  assign sel_b[0]    = in_sel_i;
  assign vld_b[0]    = in_valid_i;
  assign in_ready_o  = rdy_b[0];

  for (genvar s = 0; s < SEL_W; s++) begin : g_stage
    localparam int unsigned IW = LEAF_N >> s;
    localparam int unsigned OW = leaf_after(SEL_W, s);
    localparam int unsigned RW = sel_after(SEL_W, s);
    localparam int unsigned PW = OW + RW;

    logic [OW-1:0] fold;
    logic [PW-1:0] pay_in, pay_out;

    lut_fold #(.IN_W(IW)) u_fold (
      .in_i  (dat_b[s][IW-1:0]),
      .pick_i(sel_b[s][0]),
      .out_o (fold)
    );

    if (RW > 0) begin : g_carry
      assign pay_in     = {sel_b[s][RW:1], fold};
      assign sel_b[s+1] = SEL_W'(pay_out[PW-1:OW]);
    end else begin : g_last
      assign pay_in     = fold;
      assign sel_b[s+1] = '0;
    end

    lut_slot #(.W(PW)) u_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .valid_i(vld_b[s]),
      .ready_o(rdy_b[s]),
      .data_i (pay_in),
      .valid_o(vld_b[s+1]),
      .ready_i(rdy_b[s+1]),
      .data_o (pay_out)
    );

    assign dat_b[s+1] = LEAF_N'(pay_out[OW-1:0]);
  end

  assign rdy_b[SEL_W] = out_ready_i;
  assign out_valid_o  = vld_b[SEL_W];
  assign out_bit_o    = dat_b[SEL_W][0];

  a_r6_out_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_bit_o)));

  a_r3_ready_blocks_after_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> !in_ready_o);
endmodule

// File: tb/lut_pipe_mux_tb_top.sv
`timescale 1ns/1ps
module lut_pipe_mux_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [15:0] in_data_i = '0;
  logic [3:0]  in_sel_i = '0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b0;
  logic        out_bit_o;

  int n_chk = 0, n_bad = 0, n_acc = 0;
  bit exp_q[$];

  always #2.5 clk_i = ~clk_i;

  lut_pipe_mux dut_i (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, score handshakes before the next posedge
  task automatic cyc(input bit v, input logic [15:0] d, input logic [3:0] s, input bit r);
    @(negedge clk_i);
    in_valid_i = v; in_data_i = d; in_sel_i = s; out_ready_i = r;
    #1;
    if (out_valid_o && out_ready_i) begin
      if (exp_q.size() == 0) check(0, "R5 spurious result", 1, 0);
      else begin
        bit e;
        e = exp_q.pop_front();
        check(out_bit_o == e, "R2/R5 result", out_bit_o, e);
      end
    end
    if (in_valid_i && in_ready_o) begin
      exp_q.push_back(d[s]);
      n_acc++;
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 60 && exp_q.size() > 0; i++) cyc(0, '0, '0, 1);
    check(exp_q.size() == 0, "R5 all results delivered", exp_q.size(), 0);
    repeat (4) cyc(0, '0, '0, 1);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #7;
    check(out_valid_o == 0, "R1 out_valid after reset", out_valid_o, 0);
    check(in_ready_o == 1, "R1 in_ready after reset", in_ready_o, 1);
    @(negedge clk_i); rst_ni = 1'b1;

    // R8: throughput from reset
    n_acc = 0;
    for (int i = 0; i < 20; i++) cyc(1, 16'hA5C3 ^ 16'(i * 16'h1111), 4'(i), 1);
    check(n_acc == 10, "R8 accepts in 20 cycles", n_acc, 10);
    drain();

    // R4: isolated latency
    cyc(1, 16'h0004, 4'd2, 1);
    for (int k = 1; k <= 4; k++) begin
      cyc(0, '0, '0, 1);
      if (k < 4) check(out_valid_o == 0, "R4 early valid", out_valid_o, 0);
      else       check(out_valid_o == 1, "R4 valid at edge 4", out_valid_o, 1);
    end
    drain();

    // R2: one-hot and complement for every code
    for (int c = 0; c < 16; c++) begin
      cyc(1, 16'(1 << c), 4'(c), 1);
      cyc(1, ~16'(1 << ((c + 1) % 16)), 4'((c + 1) % 16), 1);
      cyc(1, 16'(1 << ((c + 5) % 16)), 4'(c), 1);
    end
    drain();

    // R7: occupancy limit with output stalled
    n_acc = 0;
    for (int i = 0; i < 30; i++) cyc(1, 16'hF0F0 ^ 16'(i), 4'(i), 0);
    check(n_acc == 4, "R7 tokens accepted while stalled", n_acc, 4);
    check(in_ready_o == 0, "R7 in_ready low when full", in_ready_o, 0);
    // R6: stall holds output
    begin
      bit held;
      held = out_bit_o;
      for (int i = 0; i < 5; i++) begin
        cyc(0, '0, '0, 0);
        check(out_valid_o == 1 && out_bit_o == held, "R6 output held", out_bit_o, held);
      end
    end
    drain();

    // R5: random traffic and stalls
    for (int i = 0; i < 600; i++)
      cyc(1'($urandom % 3 != 0), 16'($urandom), 4'($urandom), 1'($urandom % 2));
    drain();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule